// File: doc/BRIEF.md
# Charger and Reverse-Boost Mode Controller

This block is a synchronous state machine that sets the operating mode of a single-cell switch-mode charger that can also run backwards as a boost supply feeding the input rail. It reads five comparator flags from the analog front end: input supply above its undervoltage level, input above its minimum operating level, battery above its short threshold, battery above its low threshold, and battery above its minimum-boost threshold. It also takes two control bits (high-impedance request and boost request), a fault flag and a start-up-done pulse.

The comparator flags cross into the clock domain through two-flop synchronizers before any transition uses them. The control bits, the fault flag and the start-up pulse are taken as already synchronous. The machine has seven states: power-down, high-impedance, charge-configure, boost-configure, PWM-charge, short-circuit precharge and boost. It reports the current state as a one-hot code and drives one enable each for the charge PWM, the precharge path and the boost converter.

Top module: `charger_mode_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, the state code is 7'b0000001 (power-down) and all three enables are 0. State code bits: 0 power-down, 1 high-impedance, 2 charge-configure, 3 boost-configure, 4 PWM-charge, 5 short-circuit, 6 boost.
- R2: From any state, when the synchronized undervoltage flag and the synchronized battery-short flag are both 0, the next state is power-down. This rule overrides every other transition.
- R3: From power-down, when the synchronized undervoltage flag or the synchronized battery-short flag is 1, the next state is high-impedance.
- R4: From high-impedance, the machine moves to charge-configure when the input is above undervoltage and both control bits are 0. It moves to boost-configure when the boost bit is 1, the high-impedance bit is 0 and the battery is above its low threshold.
- R5: In either configure state, a high-impedance bit of 1 returns the machine to high-impedance. Boost-configure also returns there when the battery is not above its minimum-boost threshold.
- R6: In charge-configure with the high-impedance bit at 0, a boost bit of 1 moves the machine to boost-configure. Otherwise, with the input above its minimum and no fault, it moves to PWM-charge if the battery is above its short threshold and to short-circuit if it is not.
- R7: PWM-charge returns to charge-configure when the battery falls below its short threshold, the input falls below its minimum, or the fault flag is 1. Short-circuit returns to charge-configure when the battery rises above its short threshold, the input falls below its minimum, or the fault flag is 1.
- R8: Boost-configure enters boost on a start-up-done pulse when the fault flag is 0. Boost returns to boost-configure when the boost bit is 0 or the fault flag is 1.
- R9: A comparator change that is present at clock edge n first affects the state registered at edge n+2.
- R10: The PWM enable is 1 only in PWM-charge, the precharge enable only in short-circuit and the boost enable only in boost. At most one enable is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vin_uvlo_ok | input | 1 | Input above undervoltage lockout (asynchronous) |
| vin_min_ok | input | 1 | Input above minimum operating level (asynchronous) |
| bat_short_ok | input | 1 | Battery above short threshold (asynchronous) |
| bat_low_ok | input | 1 | Battery above low threshold (asynchronous) |
| bat_boost_ok | input | 1 | Battery above minimum-boost threshold (asynchronous) |
| hiz_req | input | 1 | High-impedance control bit |
| boost_req | input | 1 | Boost-mode control bit |
| fault | input | 1 | Fault flag |
| ss_done | input | 1 | Boost start-up completed pulse |
| state_code | output | 7 | One-hot current state |
| pwm_en | output | 1 | Charge PWM enable |
| pre_en | output | 1 | Short-circuit precharge enable |
| boost_en | output | 1 | Boost converter enable |

## Verification
The boost state is the hardest to reach from the ports. It needs the input-present rule of R2 to hold, the boost bit set with the high-impedance bit clear and the battery above both its low and minimum-boost thresholds, and then a start-up pulse that arrives with no fault. All of these must stay true through the two-cycle synchronizer delay. Random stimulus changes each input only rarely, so these conditions can persist. Directed sequences drive the boost path and the short-circuit path on purpose and hold the comparator flags long enough for the synchronized values to settle first.

// File: rtl/mode_pkg.sv
// Package: shared state encoding for the charger mode controller.
// Assumes one-hot encoding; bit positions are published on state_code.
package mode_pkg;
    localparam int NUM_STATES = 7;
    localparam int NUM_CMP    = 5;

    // Index of each comparator flag in the synchronized vector.
    localparam int CMP_UVLO  = 0;
    localparam int CMP_VMIN  = 1;
    localparam int CMP_SHORT = 2;
    localparam int CMP_LOW   = 3;
    localparam int CMP_BOOST = 4;

    typedef enum logic [NUM_STATES-1:0] {
        ST_PDOWN = 7'b0000001,
        ST_HIZ   = 7'b0000010,
        ST_CCFG  = 7'b0000100,
        ST_BCFG  = 7'b0001000,
        ST_PWM   = 7'b0010000,
        ST_SHORT = 7'b0100000,
        ST_BOOST = 7'b1000000
    } mode_t;
endpackage

// File: rtl/mode_sync.sv
// Module: mode_sync
// Two-flop synchronizer bank for asynchronous comparator flags.
// Assumes each flag is a level that is stable for several cycles; clears to 0 on reset.
module mode_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Purpose: shift each flag one stage closer to the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe[s] <= '0;
            end else if (s == 0) begin
                pipe[s] <= d_async;
            end else begin
                pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/mode_next.sv
// Module: mode_next
// Combinational next-state function of the charger mode machine.
// Assumes comparator flags are already synchronized. The rule that forces
// power-down is checked first, so it overrides all per-state transitions.
module mode_next
    import mode_pkg::*;
(
    input  mode_t                cur,
    input  logic [NUM_CMP-1:0]   cmp,
    input  logic                 hiz_req,
    input  logic                 boost_req,
    input  logic                 fault,
    input  logic                 ss_done,
    output mode_t                nxt
);
    logic uvlo, vmin, shrt, low, bst;

    assign uvlo = cmp[CMP_UVLO];
    assign vmin = cmp[CMP_VMIN];
    assign shrt = cmp[CMP_SHORT];
    assign low  = cmp[CMP_LOW];
    assign bst  = cmp[CMP_BOOST];

    // Purpose: select the next mode from the current mode and conditions.
    always_comb begin
        nxt = cur;
        if (!uvlo && !shrt) begin
            nxt = ST_PDOWN;
        end else begin
            case (cur)
                ST_PDOWN: nxt = ST_HIZ;
                ST_HIZ: begin
                    if (uvlo && !hiz_req && !boost_req)
                        nxt = ST_CCFG;
                    else if (boost_req && !hiz_req && low)
                        nxt = ST_BCFG;
                end
                ST_CCFG: begin
                    if (hiz_req)
                        nxt = ST_HIZ;
                    else if (boost_req)
                        nxt = ST_BCFG;
                    else if (vmin && !fault)
                        nxt = shrt ? ST_PWM : ST_SHORT;
                end
                ST_BCFG: begin
                    if (hiz_req || !bst)
                        nxt = ST_HIZ;
                    else if (ss_done && !fault)
                        nxt = ST_BOOST;
                end
                ST_PWM: begin
                    if (!shrt || !vmin || fault)
                        nxt = ST_CCFG;
                end
                ST_SHORT: begin
                    if (shrt || !vmin || fault)
                        nxt = ST_CCFG;
                end
                ST_BOOST: begin
                    if (!boost_req || fault)
                        nxt = ST_BCFG;
                end
                default: nxt = ST_PDOWN;
            endcase
        end
    end
endmodule

// File: rtl/mode_out.sv
// Module: mode_out
// Decodes the registered mode into converter enables.
// Assumes a one-hot mode; at most one enable can be high.
module mode_out
    import mode_pkg::*;
(
    input  mode_t cur,
    output logic  pwm_en,
    output logic  pre_en,
    output logic  boost_en
);
    // Purpose: drive exactly the enable that belongs to the active mode.
    always_comb begin
        pwm_en   = (cur == ST_PWM);
        pre_en   = (cur == ST_SHORT);
        boost_en = (cur == ST_BOOST);
    end
endmodule

// File: rtl/charger_mode_ctrl.sv
// Module: charger_mode_ctrl
// Top of the charger / reverse-boost mode controller: synchronizes the
// comparator flags, holds the mode register and decodes the enables.
// Assumes control bits, fault and ss_done are synchronous to clk.
module charger_mode_ctrl
    import mode_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vin_uvlo_ok,
    input  logic                  vin_min_ok,
    input  logic                  bat_short_ok,
    input  logic                  bat_low_ok,
    input  logic                  bat_boost_ok,
    input  logic                  hiz_req,
    input  logic                  boost_req,
    input  logic                  fault,
    input  logic                  ss_done,
    output logic [NUM_STATES-1:0] state_code,
    output logic                  pwm_en,
    output logic                  pre_en,
    output logic                  boost_en
);
    logic [NUM_CMP-1:0] cmp_raw;
    logic [NUM_CMP-1:0] cmp_s;
    mode_t              mode_q;
    mode_t              mode_d;
    logic               s_uvlo;
    logic               s_short;

    assign cmp_raw[CMP_UVLO]  = vin_uvlo_ok;
    assign cmp_raw[CMP_VMIN]  = vin_min_ok;
    assign cmp_raw[CMP_SHORT] = bat_short_ok;
    assign cmp_raw[CMP_LOW]   = bat_low_ok;
    assign cmp_raw[CMP_BOOST] = bat_boost_ok;

    assign s_uvlo  = cmp_s[CMP_UVLO];
    assign s_short = cmp_s[CMP_SHORT];

    mode_sync #(.WIDTH(NUM_CMP), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_raw),
        .q_sync  (cmp_s)
    );

    mode_next u_next (
        .cur       (mode_q),
        .cmp       (cmp_s),
        .hiz_req   (hiz_req),
        .boost_req (boost_req),
        .fault     (fault),
        .ss_done   (ss_done),
        .nxt       (mode_d)
    );

    // Purpose: mode register, parked in power-down by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= ST_PDOWN;
        else
            mode_q <= mode_d;
    end

    mode_out u_out (
        .cur      (mode_q),
        .pwm_en   (pwm_en),
        .pre_en   (pre_en),
        .boost_en (boost_en)
    );

    assign state_code = mode_q;
endmodule

// File: rtl/mode_ctrl_chk.sv
// Module: mode_ctrl_chk
// Assertion checker for charger_mode_ctrl, attached by bind below.
// Assumes visibility of the synchronized undervoltage and short flags.
module mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] state_code,
    input logic       pwm_en,
    input logic       pre_en,
    input logic       boost_en,
    input logic       s_uvlo,
    input logic       s_short,
    input logic       hiz_req,
    input logic       boost_req,
    input logic       fault
);
    logic present;
    assign present = s_uvlo || s_short;

    AST_ONEHOT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_code)); // R1
    AST_PDOWN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        !present |=> state_code == 7'b0000001); // R2
    AST_PDOWN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code[0] && present) |=> state_code == 7'b0000010); // R3
    AST_CFG_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code[2] || state_code[3]) && hiz_req && present) |=> state_code == 7'b0000010); // R5
    AST_RUN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code[4] || state_code[5]) && fault && present) |=> state_code == 7'b0000100); // R7
    AST_BOOST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code[6] && (fault || !boost_req) && present) |=> state_code == 7'b0001000); // R8
    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pwm_en, pre_en, boost_en}) <= 1); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (|state_code[3:0]) |-> !(pwm_en || pre_en || boost_en)); // R10
endmodule

bind charger_mode_ctrl mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_code (state_code),
    .pwm_en     (pwm_en),
    .pre_en     (pre_en),
    .boost_en   (boost_en),
    .s_uvlo     (s_uvlo),
    .s_short    (s_short),
    .hiz_req    (hiz_req),
    .boost_req  (boost_req),
    .fault      (fault)
);

// File: tb/tb_charger_mode_ctrl.sv
// Bench for charger_mode_ctrl: seeded random stimulus plus directed paths,
// compared each cycle against a reference model written from the requirements.
module tb_charger_mode_ctrl;
    localparam logic [6:0] PD = 7'b0000001, HZ = 7'b0000010, CC = 7'b0000100,
                           BC = 7'b0001000, PW = 7'b0010000, SC = 7'b0100000,
                           BO = 7'b1000000;

    logic clk = 0;
    logic rst_n = 0;
    logic uvlo = 0, vmin = 0, shrt = 0, low = 0, bst = 0;
    logic hiz = 0, otg = 0, flt = 0, ss = 0;
    logic [6:0] state_code;
    logic pwm_en, pre_en, boost_en;

    int n_checks = 0, n_fail = 0, cyc = 0;
    logic [6:0] exp_st = PD;
    logic [4:0] s1 = '0, s2 = '0; // bench-side 2-cycle delay of comparators (R9)
    string last_tag = "R1";

    always #2 clk = ~clk; // 250 MHz

    charger_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .vin_uvlo_ok(uvlo), .vin_min_ok(vmin), .bat_short_ok(shrt),
        .bat_low_ok(low), .bat_boost_ok(bst),
        .hiz_req(hiz), .boost_req(otg), .fault(flt), .ss_done(ss),
        .state_code(state_code), .pwm_en(pwm_en), .pre_en(pre_en), .boost_en(boost_en)
    );

    // Reference next mode; c = {bst, low, shrt, vmin, uvlo}; tag names the rule used.
    function automatic logic [6:0] ref_next(input logic [6:0] st, input logic [4:0] c,
                                            output string tag);
        logic u = c[0], v = c[1], s = c[2], l = c[3], b = c[4];
        tag = "R4";
        if (!u && !s) begin tag = "R2"; return PD; end
        case (st)
            PD: begin tag = "R3"; return HZ; end
            HZ: begin
                tag = "R4";
                if (u && !hiz && !otg) return CC;
                if (otg && !hiz && l) return BC;
                return HZ;
            end
            CC: begin
                if (hiz) begin tag = "R5"; return HZ; end
                tag = "R6";
                if (otg) return BC;
                if (v && !flt) return s ? PW : SC;
                return CC;
            end
            BC: begin
                if (hiz || !b) begin tag = "R5"; return HZ; end
                tag = "R8";
                if (ss && !flt) return BO;
                return BC;
            end
            PW: begin tag = "R7"; return (!s || !v || flt) ? CC : PW; end
            SC: begin tag = "R7"; return (s || !v || flt) ? CC : SC; end
            BO: begin tag = "R8"; return (!otg || flt) ? BC : BO; end
            default: return PD;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, exp);
        end
    endtask

    function automatic logic [2:0] exp_en(input logic [6:0] st);
        return {st == BO, st == SC, st == PW}; // R10
    endfunction

    // One clock: model update after the edge, compare at the falling edge.
    task automatic step();
        string tg;
        @(posedge clk);
        #1;
        cyc++;
        exp_st = ref_next(exp_st, s2, tg);
        last_tag = tg;
        s2 = s1;
        s1 = {bst, low, shrt, vmin, uvlo};
        @(negedge clk);
        chk(last_tag, {state_code, boost_en, pre_en, pwm_en}, {exp_st, exp_en(exp_st)});
        chk("R10", {7'b0, boost_en, pre_en, pwm_en}, {7'b0, exp_en(exp_st)});
    endtask

    task automatic set_cmp(input logic u, input logic v, input logic s,
                           input logic l, input logic b);
        uvlo = u; vmin = v; shrt = s; low = l; bst = b;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int unused;
        unused = $urandom(32'd1234);
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", {state_code, boost_en, pre_en, pwm_en}, {PD, 3'b000});
        set_cmp(1, 1, 1, 1, 1);
        @(negedge clk);
        rst_n = 1;
        exp_st = PD; s1 = '0; s2 = '0;
        @(posedge clk); #1; cyc++;
        exp_st = PD; s2 = s1; s1 = {bst, low, shrt, vmin, uvlo};
        @(negedge clk);
        chk("R1", {state_code, boost_en, pre_en, pwm_en}, {PD, 3'b000});

        // R9: the flags were raised before the first edge; PD still one edge later.
        step();
        chk("R9", {3'b0, state_code}, {3'b0, PD});
        step();
        chk("R9", {3'b0, state_code}, {3'b0, HZ});   // R3 entry two edges after the sync

        // Directed charge path: HIZ -> CCFG -> PWM, then battery short -> SC
        step();
        chk("R4", {3'b0, state_code}, {3'b0, CC});
        step();
        chk("R6", {3'b0, state_code}, {3'b0, PW});
        set_cmp(1, 1, 0, 1, 1);
        step(); step();
        chk("R7", {3'b0, state_code}, {3'b0, PW});  // sync delay still holding
        step();
        chk("R7", {3'b0, state_code}, {3'b0, CC});
        step();
        chk("R6", {3'b0, state_code}, {3'b0, SC});
        flt = 1;
        step();
        chk("R7", {3'b0, state_code}, {3'b0, CC});
        flt = 0;

        // Directed boost path
        otg = 1;
        step();
        chk("R6", {3'b0, state_code}, {3'b0, BC});
        step();
        chk("R8", {3'b0, state_code}, {3'b0, BC});
        ss = 1;
        step();
        ss = 0;
        chk("R8", {3'b0, state_code}, {3'b0, BO});
        chk("R10", {7'b0, boost_en, pre_en, pwm_en}, {7'b0, 3'b100});
        otg = 0;
        step();
        chk("R8", {3'b0, state_code}, {3'b0, BC});
        hiz = 1;
        step();
        chk("R5", {3'b0, state_code}, {3'b0, HZ});
        hiz = 0;
        // Remove everything: power-down after sync delay
        set_cmp(0, 0, 0, 0, 0);
        step(); step(); step();
        chk("R2", {3'b0, state_code}, {3'b0, PD});

        // Random phase: rare toggles so deep states stay reachable.
        set_cmp(1, 1, 1, 1, 1);
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 40 == 0) uvlo = ~uvlo;
            if ($urandom % 30 == 0) vmin = ~vmin;
            if ($urandom % 30 == 0) shrt = ~shrt;
            if ($urandom % 50 == 0) low  = ~low;
            if ($urandom % 50 == 0) bst  = ~bst;
            if ($urandom % 25 == 0) hiz  = ~hiz;
            if (hiz && ($urandom % 3 == 0)) hiz = 0;
            if ($urandom % 20 == 0) otg  = ~otg;
            flt = ($urandom % 25 == 0);
            ss  = ($urandom % 6 == 0);
            step();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule